// File: doc/BRIEF.md
# Four-Tile Store Arrival Mask with Two-Way Forwarding

The block holds, in each of four tiles, a 256-entry bit vector that records which speculative stores have arrived anywhere in the load/store queue. A tile learns of a store either because the store lands on it, or because a neighbour passes the notice on. Each tile accepts at most one local arrival per cycle. Notices hop one tile per clock in both directions, so every tile sees every arrival after a fixed delay equal to its distance from the source tile. Completion logic and deferred-load wakeup read the vectors. They are not part of this block.

Entries are grouped into eight instruction blocks of 32 entries each. A block-level flush or commit mask is widened to 256 bits and wipes the matching entries in every tile. Notices still travelling between tiles for a wiped block are dropped, so a stale notice cannot bring a bit back.

Top module: `stm_array`

## Requirements
- R1: While reset is held and right after it is released, every bit of `tile_mask` is 0.
- R2: When `arr_vld[t]` is 1 with index x on `arr_idx[8t+7:8t]`, bit x of tile t's vector (`tile_mask[256t+x]`) is 1 after the next rising clock edge, unless x's block is wiped on that same edge.
- R3: An arrival at tile i reaches tile j after |i-j| further edges. Upward notices travel toward tile 0 and downward notices toward tile 3.
- R4: All four tiles may accept an arrival in the same cycle, every cycle, and no notice is lost. After a full sweep of all 256 indices, every tile shows all ones three edges after the last arrival.
- R5: Bit b of `flush_blk` clears entries 32b to 32b+31 (the block of entry x is x/32) in all tiles on the next edge. All other entries keep their values.
- R6: `commit_blk` clears entries exactly as `flush_blk` does. Both may be active in one cycle for different blocks, and their effects combine.
- R7: A notice whose block is flushed or committed on the edge where it arrives, or on any edge while it is still travelling, never sets a bit in any tile.
- R8: With `arr_vld[t]` at 0, the value on tile t's index lane has no effect on any vector.
- R9: Each direction carries at most three notices per hop. A forwarding tile never receives a notice in its last incoming slot, because that slot is not passed on.
- R10: A set bit stays set until its block is flushed or committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_vld | input | 4 | Local store arrival valid, one bit per tile |
| arr_idx | input | 32 | Store index per tile, tile t in bits [8t+7:8t] |
| flush_blk | input | 8 | Per-block flush request |
| commit_blk | input | 8 | Per-block commit request |
| tile_mask | output | 1024 | Arrived-store vector, tile t in bits [256t+255:256t] |

## Verification
A local arrival shows in its own tile after one edge. It shows in a tile d positions away after 1+d edges in total counted from the input. A flush or commit takes effect on the edge that samples it. The bench stamps each arrival and each clear with the number of the edge that samples it. After every edge it samples the outputs at the falling clock. A bit is expected at tile j once the edge count reaches the arrival stamp plus the distance, provided no clear of that block carries a stamp at or after the arrival. All four full vectors are compared on every cycle, so any result that comes one edge early or late is caught.

// File: rtl/stm_pkg.sv
package stm_pkg;
    localparam int STM_TILES   = 4;
    localparam int STM_ENTRIES = 256;
    localparam int STM_BLOCKS  = 8;

    // bit position of the block field inside an entry index
    function automatic int blk_shift(int entries, int blocks);
        return $clog2(entries / blocks);
    endfunction
endpackage

// File: rtl/stm_decode.sv
module stm_decode #(
    parameter int ENTRIES = 256,
    parameter int NUM     = 3,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic [NUM-1:0]    vld,
    input  logic [NUM*IW-1:0] idx,
    output logic [ENTRIES-1:0] hits
);
    always_comb begin
        hits = '0;
        for (int n = 0; n < NUM; n++) begin
            if (vld[n]) hits[idx[n*IW +: IW]] = 1'b1;
        end
    end
endmodule

// File: rtl/stm_expand.sv
module stm_expand #(
    parameter int ENTRIES = 256,
    parameter int BLOCKS  = 8
) (
    input  logic [BLOCKS-1:0]  blk,
    output logic [ENTRIES-1:0] wide
);
    localparam int PER = ENTRIES / BLOCKS;

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        assign wide[b*PER +: PER] = {PER{blk[b]}};
    end
endmodule

// File: rtl/stm_link.sv
module stm_link
    import stm_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int BLOCKS  = 8,
    parameter int SLOTS   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOTS-1:0]         in_vld,
    input  logic [SLOTS*$clog2(ENTRIES)-1:0] in_idx,
    input  logic [BLOCKS-1:0]        clr_blk,
    output logic [SLOTS-1:0]         out_vld,
    output logic [SLOTS*$clog2(ENTRIES)-1:0] out_idx
);
    localparam int IW = $clog2(ENTRIES);
    localparam int SH = blk_shift(ENTRIES, BLOCKS);
    localparam int BW = IW - SH;

    logic [SLOTS-1:0] keep;

    // a notice for a block wiped on this edge is not carried further
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            keep[s] = in_vld[s] & ~clr_blk[in_idx[s*IW+SH +: BW]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= '0;
            out_idx <= '0;
        end else begin
            out_vld <= keep;
            out_idx <= in_idx;
        end
    end
endmodule

// File: rtl/stm_tile.sv
module stm_tile #(
    parameter int ENTRIES = 256,
    parameter int SLOTS   = 3,
    parameter bit UP_EN   = 1'b1,
    parameter bit DN_EN   = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     loc_vld,
    input  logic [$clog2(ENTRIES)-1:0] loc_idx,
    input  logic [SLOTS-1:0]         abv_vld,
    input  logic [SLOTS*$clog2(ENTRIES)-1:0] abv_idx,
    input  logic [SLOTS-1:0]         blw_vld,
    input  logic [SLOTS*$clog2(ENTRIES)-1:0] blw_idx,
    input  logic [ENTRIES-1:0]       clr_wide,
    output logic [SLOTS-1:0]         up_vld,
    output logic [SLOTS*$clog2(ENTRIES)-1:0] up_idx,
    output logic [SLOTS-1:0]         dn_vld,
    output logic [SLOTS*$clog2(ENTRIES)-1:0] dn_idx,
    output logic [ENTRIES-1:0]       mask
);
    localparam int IW  = $clog2(ENTRIES);
    localparam int NIN = 2 * SLOTS + 1;

    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] mask_q;

    stm_decode #(.ENTRIES(ENTRIES), .NUM(NIN), .IW(IW)) u_dec (
        .vld  ({blw_vld, abv_vld, loc_vld}),
        .idx  ({blw_idx, abv_idx, loc_idx}),
        .hits (hits)
    );

    // slot 0 carries the local arrival, the rest pass on what came
    // from the opposite side, shifted by one slot
    always_comb begin
        up_vld = '0;
        up_idx = '0;
        dn_vld = '0;
        dn_idx = '0;
        if (UP_EN) begin
            up_vld = {abv_vld[SLOTS-2:0], loc_vld};
            up_idx = {abv_idx[(SLOTS-1)*IW-1:0], loc_idx};
        end
        if (DN_EN) begin
            dn_vld = {blw_vld[SLOTS-2:0], loc_vld};
            dn_idx = {blw_idx[(SLOTS-1)*IW-1:0], loc_idx};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | hits) & ~clr_wide;
    end

    assign mask = mask_q;

    // R2: an unwiped local arrival is recorded on the next edge
    a_r2_local_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_vld && !clr_wide[loc_idx]) |=> mask_q[$past(loc_idx)]);

    // R5 / R6: a wiped entry is zero after the edge
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mask_q & $past(clr_wide)) == '0));

    // R10: only a wipe may drop a set bit
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(mask_q) & ~$past(clr_wide) & ~mask_q) == '0));

    // R9: the dropped last slot is never occupied on a forwarding tile
    if (UP_EN) begin : g_up_chk
        a_r9_no_slot_loss_up: assert property (@(posedge clk) disable iff (!rst_n)
            !abv_vld[SLOTS-1]);
    end
    if (DN_EN) begin : g_dn_chk
        a_r9_no_slot_loss_dn: assert property (@(posedge clk) disable iff (!rst_n)
            !blw_vld[SLOTS-1]);
    end
endmodule

// File: rtl/stm_array.sv
module stm_array
    import stm_pkg::*;
#(
    parameter int TILES   = STM_TILES,
    parameter int ENTRIES = STM_ENTRIES,
    parameter int BLOCKS  = STM_BLOCKS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [TILES-1:0]               arr_vld,
    input  logic [TILES*$clog2(ENTRIES)-1:0] arr_idx,
    input  logic [BLOCKS-1:0]              flush_blk,
    input  logic [BLOCKS-1:0]              commit_blk,
    output logic [TILES*ENTRIES-1:0]       tile_mask
);
    localparam int IW    = $clog2(ENTRIES);
    localparam int SLOTS = TILES - 1;

    logic [BLOCKS-1:0]   clr_blk;
    logic [ENTRIES-1:0]  clr_wide;

    logic [SLOTS-1:0]    up_o_vld [TILES];
    logic [SLOTS*IW-1:0] up_o_idx [TILES];
    logic [SLOTS-1:0]    dn_o_vld [TILES];
    logic [SLOTS*IW-1:0] dn_o_idx [TILES];
    logic [SLOTS-1:0]    up_i_vld [TILES];
    logic [SLOTS*IW-1:0] up_i_idx [TILES];
    logic [SLOTS-1:0]    dn_i_vld [TILES];
    logic [SLOTS*IW-1:0] dn_i_idx [TILES];

    assign clr_blk = flush_blk | commit_blk;

    stm_expand #(.ENTRIES(ENTRIES), .BLOCKS(BLOCKS)) u_exp (
        .blk  (clr_blk),
        .wide (clr_wide)
    );

    for (genvar t = 0; t < TILES; t++) begin : g_tile
        // the end tiles' silent outputs close the ring, so every link exists
        localparam int UP_SRC = (t + 1) % TILES;
        localparam int DN_SRC = (t + TILES - 1) % TILES;

        stm_tile #(
            .ENTRIES (ENTRIES),
            .SLOTS   (SLOTS),
            .UP_EN   (t != 0),
            .DN_EN   (t != TILES - 1)
        ) u_tile (
            .clk      (clk),
            .rst_n    (rst_n),
            .loc_vld  (arr_vld[t]),
            .loc_idx  (arr_idx[t*IW +: IW]),
            .abv_vld  (up_i_vld[t]),
            .abv_idx  (up_i_idx[t]),
            .blw_vld  (dn_i_vld[t]),
            .blw_idx  (dn_i_idx[t]),
            .clr_wide (clr_wide),
            .up_vld   (up_o_vld[t]),
            .up_idx   (up_o_idx[t]),
            .dn_vld   (dn_o_vld[t]),
            .dn_idx   (dn_o_idx[t]),
            .mask     (tile_mask[t*ENTRIES +: ENTRIES])
        );

        stm_link #(.ENTRIES(ENTRIES), .BLOCKS(BLOCKS), .SLOTS(SLOTS)) u_up_lnk (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (up_o_vld[UP_SRC]),
            .in_idx  (up_o_idx[UP_SRC]),
            .clr_blk (clr_blk),
            .out_vld (up_i_vld[t]),
            .out_idx (up_i_idx[t])
        );

        stm_link #(.ENTRIES(ENTRIES), .BLOCKS(BLOCKS), .SLOTS(SLOTS)) u_dn_lnk (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (dn_o_vld[DN_SRC]),
            .in_idx  (dn_o_idx[DN_SRC]),
            .clr_blk (clr_blk),
            .out_vld (dn_i_vld[t]),
            .out_idx (dn_i_idx[t])
        );
    end

    // R1: vectors are empty on the first edge after reset
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tile_mask == '0));
endmodule

// File: tb/sim_stm_array.sv
module sim_stm_array;
    localparam int CLK_PERIOD = 10;
    localparam int T   = 4;
    localparam int E   = 256;
    localparam int B   = 8;
    localparam int IW  = 8;
    localparam int PER = E / B;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [T-1:0]     arr_vld = '0;
    logic [T*IW-1:0]  arr_idx = '0;
    logic [B-1:0]     flush_blk = '0;
    logic [B-1:0]     commit_blk = '0;
    logic [T*E-1:0]   tile_mask;

    int n_checks = 0;
    int n_errs   = 0;
    int edge_n   = 0;
    int arr_t [T][E];
    int clr_t [B];

    always #(CLK_PERIOD/2) clk = ~clk;

    stm_array u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .arr_vld    (arr_vld),
        .arr_idx    (arr_idx),
        .flush_blk  (flush_blk),
        .commit_blk (commit_blk),
        .tile_mask  (tile_mask)
    );

    // expected bit: arrival stamp plus hop distance reached, no wipe since arrival
    function automatic bit exp_bit(int j, int x);
        for (int i = 0; i < T; i++) begin
            int a = arr_t[i][x];
            int d = (i > j) ? i - j : j - i;
            if (a >= 0 && a + d <= edge_n && clr_t[x / PER] < a) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check_all(string req);
        for (int j = 0; j < T; j++) begin
            logic [E-1:0] ex;
            for (int x = 0; x < E; x++) ex[x] = exp_bit(j, x);
            n_checks++;
            if (tile_mask[j*E +: E] !== ex) begin
                n_errs++;
                $display("FAIL %s tile %0d edge %0d: got %h expected %h",
                         req, j, edge_n, tile_mask[j*E +: E], ex);
            end
        end
    endtask

    // stamp the stimulus with the edge that samples it, clock it, check
    task automatic step(string req);
        for (int i = 0; i < T; i++)
            if (arr_vld[i]) arr_t[i][arr_idx[i*IW +: IW]] = edge_n + 1;
        for (int b = 0; b < B; b++)
            if (flush_blk[b] || commit_blk[b]) clr_t[b] = edge_n + 1;
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        arr_vld    = '0;
        flush_blk  = '0;
        commit_blk = '0;
        check_all(req);
    endtask

    task automatic arrive(int t, int x);
        arr_vld[t] = 1'b1;
        arr_idx[t*IW +: IW] = x[IW-1:0];
    endtask

    task automatic sweep_all(string req);
        for (int k = 0; k < E / T; k++) begin
            for (int t = 0; t < T; t++) arrive(t, t * (E / T) + k);
            step(req);
        end
        for (int w = 0; w < T; w++) step(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog (run hung): got no finish, expected finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < T; i++)
            for (int x = 0; x < E; x++) arr_t[i][x] = -1;
        for (int b = 0; b < B; b++) clr_t[b] = -1;

        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step("R1");
        step("R1");

        // R2 and R3: single arrivals from each tile, hop timing per cycle
        for (int s = 0; s < T; s++) begin
            arrive(s, 70 + 9 * s);
            step("R2");
            for (int w = 0; w < T; w++) step("R3");
        end
        flush_blk = '1;
        step("R5");

        // R4: every tile takes an arrival every cycle, full sweep
        sweep_all("R4");
        step("R10");

        // R5: one block flushed at a time, the rest must stay
        for (int b = 0; b < B; b++) begin
            flush_blk = 8'(1 << b);
            step("R5");
        end

        // R6: refill, then commits, including mixed with flush
        sweep_all("R4");
        commit_blk = 8'h05;
        step("R6");
        commit_blk = 8'h10;
        flush_blk  = 8'h20;
        step("R6");
        commit_blk = 8'h82;
        flush_blk  = 8'h02;
        step("R6");
        step("R10");

        // R7: wipe the block while the notice is in flight (gap 0..3)
        flush_blk = '1;
        step("R5");
        for (int s = 0; s < T; s++) begin
            for (int g = 0; g < T; g++) begin
                arrive(s, 2 * PER + 5 * s + g);
                if (g == 0) begin
                    if (s[0]) commit_blk = 8'h04;
                    else      flush_blk  = 8'h04;
                end
                step("R7");
                for (int w = 1; w < g; w++) step("R7");
                if (g > 0) begin
                    if (s[0]) commit_blk = 8'h04;
                    else      flush_blk  = 8'h04;
                    step("R7");
                end
                for (int w = 0; w < T; w++) step("R7");
            end
        end

        // R8: index lanes toggle with valid low
        arrive(2, 5 * PER + 3);
        for (int w = 0; w < T; w++) step("R8");
        for (int k = 0; k < 16; k++) begin
            arr_idx = 32'(k * 32'h1F3B_57A9);
            step("R8");
        end

        // R9: both end tiles stream arrivals, deepest slot use
        for (int k = 0; k < 20; k++) begin
            arrive(0, 6 * PER + k);
            arrive(3, 7 * PER + k);
            if (k[0]) arrive(1, PER + k);
            step("R9");
        end
        for (int w = 0; w < T; w++) step("R9");

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule